// File: doc/BRIEF.md
# Multi-Line Transmit DMA Sequencer

This block keeps up to sixteen serial transmitters supplied with characters taken from memory. For every line it holds a current buffer address and a remaining byte count in a small shared pointer store inside the block. The host loads a line's pointer pair through a single configuration port, and the load marks the line as busy.

The engine looks for lines that are busy, enabled and have an empty transmit holding register. It picks the next such line in rotating order, starting just after the line it served last. For that line it fetches exactly one byte over a simple request/grant/data memory port. It hands the byte to the line, advances the address and lowers the count.

When the count runs out, the line stops being busy and a one-cycle completion pulse reports the line number. If memory does not answer within a fixed window after the grant, the line is dropped, a fault pulse is raised, the faulting line number is kept for the host, and service of the other lines continues.

Top module: `txdma_seq`

## Requirements
- R1: While and after reset, `mem_req`, `tx_load`, `done_irq` and `nxm_irq` are low, `line_active` is all zeros and `nxm_line` is zero.
- R2: A cycle with `cfg_we` high stores `cfg_addr` and `cfg_count` for line `cfg_line`. Bit `cfg_line` of `line_active` becomes 1 on the next cycle if `cfg_count` is nonzero. If the count is zero the bit becomes 0 and the line is never fetched.
- R3: A line is fetched only while its `line_active`, `line_en` and `thr_empty` bits are all 1. If either of the last two is 0, the line keeps its active bit and gets no fetch.
- R4: `mem_req` stays high with a constant `mem_addr` until a cycle in which `mem_gnt` is high. Exactly one request, for exactly one byte, is made per fetch, and no new request is made while a granted read is outstanding.
- R5: When `mem_rvalid` is sampled high, `tx_load` is high for exactly the following cycle. In that cycle `tx_line` is the served line and `tx_data` is the `mem_rdata` value.
- R6: Successive fetches for one line use consecutive byte addresses, starting at the loaded address and rising by one per byte.
- R7: The fetch that brings a line's count to zero clears its active bit. In the same cycle as that fetch's `tx_load`, a one-cycle `done_irq` pulse is raised with `done_line` equal to the line. A line loaded with count N delivers exactly N bytes.
- R8: Service is round-robin. After line k is served, the next line chosen is the first eligible line in the order k+1, k+2, … wrapping at the line count. After reset the search starts at line 0.
- R9: `TMO_CYC` (8) cycles are counted after the grant, starting with the cycle after the grant edge. If `mem_rvalid` is still low after them, a one-cycle `nxm_irq` pulse is raised and the line's active bit is cleared. The pulse is visible `TMO_CYC`+1 cycles after the grant cycle. `nxm_line` takes the line number and holds it until the next fault, and other lines continue to be served. A response in the last cycle of the window is accepted as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load pointer pair for one line |
| cfg_line | input | LINE_W (4) | Line being loaded |
| cfg_addr | input | ADDR_W (18) | Start byte address |
| cfg_count | input | CNT_W (16) | Number of bytes to send |
| line_en | input | NLINES (16) | Transmitter enable per line |
| thr_empty | input | NLINES (16) | Transmit holding register empty per line |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W (18) | Byte address of the read |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W (8) | Read byte |
| tx_load | output | 1 | One-cycle byte hand-off strobe |
| tx_line | output | LINE_W (4) | Line receiving the byte |
| tx_data | output | DATA_W (8) | Byte for the line |
| done_irq | output | 1 | String complete pulse |
| done_line | output | LINE_W (4) | Line whose string completed |
| nxm_irq | output | 1 | Memory no-response pulse |
| nxm_line | output | LINE_W (4) | Line of the most recent fault (held) |
| line_active | output | NLINES (16) | Busy bit per line |

## Verification
The checker watches the request handshake on every cycle: the address is held while a request waits, and no new request goes out while a granted read is pending. It also checks that every byte strobe follows a data response, that busy bits only rise after a host load, and that each completion or fault pulse leaves that line idle. A counter in the checker bounds the wait after a grant and pins the fault pulse to exactly the end of the window. The bench scenarios are needed for the values that cannot be seen on one cycle: the byte order across lines under round-robin, the address sequence and total byte count per string, and a zero-length load that never starts. They also cover the eligibility gating by enable and holding-register state, a response landing on the last cycle of the window, and service continuing after a fault.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    localparam int MAX_LINES = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        FR_NONE  = 2'd0,
        FR_BYTE  = 2'd1,
        FR_FAULT = 2'd2
    } fetch_res_e;

    function automatic logic cnt_is_last(input logic [31:0] cnt);
        return cnt <= 32'd1;
    endfunction

endpackage

// File: rtl/txdma_ptr_ram.sv
module txdma_ptr_ram #(
    parameter int NLINES = 16,
    parameter int ADDR_W = 18,
    parameter int CNT_W  = 16,
    localparam int LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              h_we,
    input  logic [LINE_W-1:0] h_idx,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [CNT_W-1:0]  h_cnt,
    input  logic              e_we,
    input  logic [LINE_W-1:0] e_idx,
    input  logic [ADDR_W-1:0] e_addr,
    input  logic [CNT_W-1:0]  e_cnt,
    input  logic [LINE_W-1:0] r_idx,
    output logic [ADDR_W-1:0] r_addr,
    output logic [CNT_W-1:0]  r_cnt
);
    logic [ADDR_W-1:0] addr_mem [NLINES];
    logic [CNT_W-1:0]  cnt_mem  [NLINES];

    logic e_blocked;
    assign e_blocked = h_we && (h_idx == e_idx);

    // Host load wins over engine write-back to the same line.
    always_ff @(posedge clk) begin
        if (e_we && !e_blocked && (int'(e_idx) < NLINES)) begin
            addr_mem[e_idx] <= e_addr;
            cnt_mem[e_idx]  <= e_cnt;
        end
        if (h_we && (int'(h_idx) < NLINES)) begin
            addr_mem[h_idx] <= h_addr;
            cnt_mem[h_idx]  <= h_cnt;
        end
    end

    always_comb begin
        r_addr = '0;
        r_cnt  = '0;
        if (int'(r_idx) < NLINES) begin
            r_addr = addr_mem[r_idx];
            r_cnt  = cnt_mem[r_idx];
        end
    end
endmodule

// File: rtl/txdma_rr_arb.sv
module txdma_rr_arb #(
    parameter int NLINES = 16,
    localparam int LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic [NLINES-1:0] req,
    input  logic [LINE_W-1:0] last,
    output logic              hit,
    output logic [LINE_W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 1; k <= NLINES; k++) begin
            int c;
            c = (int'(last) + k) % NLINES;
            if (!hit && req[c]) begin
                hit = 1'b1;
                idx = LINE_W'(c);
            end
        end
    end
endmodule

// File: rtl/txdma_bus_timer.sv
module txdma_bus_timer #(
    parameter int TMO_CYC = 8,
    localparam int TW = $clog2(TMO_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == TW'(TMO_CYC - 1));
endmodule

// File: rtl/txdma_seq.sv
module txdma_seq
    import txdma_pkg::*;
#(
    parameter int NLINES  = 16,
    parameter int ADDR_W  = 18,
    parameter int CNT_W   = 16,
    parameter int DATA_W  = 8,
    parameter int TMO_CYC = 8,
    localparam int LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [LINE_W-1:0] cfg_line,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [NLINES-1:0] line_en,
    input  logic [NLINES-1:0] thr_empty,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              tx_load,
    output logic [LINE_W-1:0] tx_line,
    output logic [DATA_W-1:0] tx_data,
    output logic              done_irq,
    output logic [LINE_W-1:0] done_line,
    output logic              nxm_irq,
    output logic [LINE_W-1:0] nxm_line,
    output logic [NLINES-1:0] line_active
);
    seq_state_e        state;
    fetch_res_e        res;
    logic [LINE_W-1:0] sel;
    logic [LINE_W-1:0] last;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_cnt;
    logic [NLINES-1:0] active;
    logic [NLINES-1:0] active_nx;
    logic [NLINES-1:0] cand;

    logic              arb_hit;
    logic [LINE_W-1:0] arb_idx;
    logic [ADDR_W-1:0] rd_addr;
    logic [CNT_W-1:0]  rd_cnt;
    logic              tmo_expired;
    logic              last_byte;
    logic              granted;

    assign cand      = active & line_en & thr_empty;
    assign last_byte = cnt_is_last(32'(cur_cnt));
    assign granted   = (state == ST_REQ) && mem_gnt;

    txdma_rr_arb #(.NLINES(NLINES)) u_arb (
        .req  (cand),
        .last (last),
        .hit  (arb_hit),
        .idx  (arb_idx)
    );

    txdma_ptr_ram #(.NLINES(NLINES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ram (
        .clk    (clk),
        .h_we   (cfg_we),
        .h_idx  (cfg_line),
        .h_addr (cfg_addr),
        .h_cnt  (cfg_count),
        .e_we   (res == FR_BYTE),
        .e_idx  (sel),
        .e_addr (cur_addr + 1'b1),
        .e_cnt  (last_byte ? '0 : cur_cnt - 1'b1),
        .r_idx  (arb_idx),
        .r_addr (rd_addr),
        .r_cnt  (rd_cnt)
    );

    txdma_bus_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .start   (granted),
        .run     (state == ST_WAIT),
        .expired (tmo_expired)
    );

    // Outcome of the outstanding read in this cycle.
    always_comb begin
        res = FR_NONE;
        if (state == ST_WAIT) begin
            if (mem_rvalid)       res = FR_BYTE;
            else if (tmo_expired) res = FR_FAULT;
        end
    end

    // Busy bits: engine clears, host load (later, so it wins) sets or clears.
    always_comb begin
        active_nx = active;
        if ((res == FR_FAULT) || (res == FR_BYTE && last_byte)) begin
            active_nx[sel] = 1'b0;
        end
        if (cfg_we && (int'(cfg_line) < NLINES)) begin
            active_nx[cfg_line] = (cfg_count != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            sel       <= '0;
            last      <= LINE_W'(NLINES - 1);
            cur_addr  <= '0;
            cur_cnt   <= '0;
            active    <= '0;
            tx_load   <= 1'b0;
            tx_line   <= '0;
            tx_data   <= '0;
            done_irq  <= 1'b0;
            done_line <= '0;
            nxm_irq   <= 1'b0;
            nxm_line  <= '0;
        end else begin
            active   <= active_nx;
            tx_load  <= 1'b0;
            done_irq <= 1'b0;
            nxm_irq  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (arb_hit) begin
                        sel      <= arb_idx;
                        cur_addr <= rd_addr;
                        cur_cnt  <= rd_cnt;
                        state    <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mem_gnt) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (res == FR_BYTE) begin
                        tx_load <= 1'b1;
                        tx_line <= sel;
                        tx_data <= mem_rdata;
                        last    <= sel;
                        state   <= ST_IDLE;
                        if (last_byte) begin
                            done_irq  <= 1'b1;
                            done_line <= sel;
                        end
                    end else if (res == FR_FAULT) begin
                        nxm_irq  <= 1'b1;
                        nxm_line <= sel;
                        last     <= sel;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req     = (state == ST_REQ);
    assign mem_addr    = cur_addr;
    assign line_active = active;
endmodule

// File: rtl/txdma_seq_chk.sv
module txdma_seq_chk #(
    parameter int NLINES  = 16,
    parameter int ADDR_W  = 18,
    parameter int TMO_CYC = 8,
    localparam int LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1,
    localparam int PW = $clog2(TMO_CYC + 2)
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_gnt,
    input logic              mem_rvalid,
    input logic              tx_load,
    input logic              done_irq,
    input logic [LINE_W-1:0] done_line,
    input logic              nxm_irq,
    input logic [LINE_W-1:0] nxm_line,
    input logic [NLINES-1:0] line_active
);
    logic          pend;
    logic [PW-1:0] pend_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            pend_cnt <= '0;
        end else if (mem_req && mem_gnt) begin
            pend     <= 1'b1;
            pend_cnt <= '0;
        end else if (pend && (mem_rvalid || nxm_irq)) begin
            pend     <= 1'b0;
        end else if (pend && pend_cnt <= PW'(TMO_CYC)) begin
            pend_cnt <= pend_cnt + 1'b1;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr))); // R4
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        pend |-> !mem_req); // R4
    AST_LOAD_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        tx_load |-> $past(mem_rvalid)); // R5
    AST_ACTIVE_FROM_CFG: assert property (@(posedge clk) disable iff (rst)
        ((line_active & ~$past(line_active)) != '0) |-> $past(cfg_we)); // R2
    AST_DONE_IDLES: assert property (@(posedge clk) disable iff (rst)
        (done_irq && !$past(cfg_we)) |-> !line_active[done_line]); // R7
    AST_NXM_IDLES: assert property (@(posedge clk) disable iff (rst)
        (nxm_irq && !$past(cfg_we)) |-> !line_active[nxm_line]); // R9
    AST_NXM_AT_WINDOW_END: assert property (@(posedge clk) disable iff (rst)
        nxm_irq |-> (pend && pend_cnt == PW'(TMO_CYC))); // R9
    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        pend |-> (pend_cnt <= PW'(TMO_CYC))); // R9
    AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done_irq && nxm_irq)); // R7
endmodule

bind txdma_seq txdma_seq_chk #(
    .NLINES  (NLINES),
    .ADDR_W  (ADDR_W),
    .TMO_CYC (TMO_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_gnt     (mem_gnt),
    .mem_rvalid  (mem_rvalid),
    .tx_load     (tx_load),
    .done_irq    (done_irq),
    .done_line   (done_line),
    .nxm_irq     (nxm_irq),
    .nxm_line    (nxm_line),
    .line_active (line_active)
);

// File: tb/txdma_seq_tb.sv
`timescale 1ns/1ps
module txdma_seq_tb;
    localparam int NL  = 16;
    localparam int AW  = 18;
    localparam int CW  = 16;
    localparam int DW  = 8;
    localparam int TMO = 8;
    localparam int LW  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [LW-1:0] cfg_line = '0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [NL-1:0] line_en = '0;
    logic [NL-1:0] thr_empty = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_gnt = 1'b0;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          tx_load;
    logic [LW-1:0] tx_line;
    logic [DW-1:0] tx_data;
    logic          done_irq;
    logic [LW-1:0] done_line;
    logic          nxm_irq;
    logic [LW-1:0] nxm_line;
    logic [NL-1:0] line_active;

    always #2.5 clk = ~clk;

    txdma_seq u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_line(cfg_line),
        .cfg_addr(cfg_addr), .cfg_count(cfg_count), .line_en(line_en),
        .thr_empty(thr_empty), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_load(tx_load), .tx_line(tx_line), .tx_data(tx_data),
        .done_irq(done_irq), .done_line(done_line), .nxm_irq(nxm_irq),
        .nxm_line(nxm_line), .line_active(line_active)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Memory model and output log, all updated at the falling edge.
    int resp_delay = 2;
    int gnt_delay = 0;
    int cyc = 0;
    bit busy = 1'b0;
    int wcnt = 0;
    int hold = 0;
    logic [AW-1:0] req_addr = '0;
    logic [AW-1:0] first_addr = '0;
    int addr_moved = 0;

    int ld_n = 0;
    int ld_line [64];
    int ld_data [64];
    int ga_n = 0;
    int ga_addr [64];
    int ga_cyc [64];
    int dn_n = 0;
    int dn_line [16];
    int nx_n = 0;
    int nx_cyc = 0;

    function automatic logic [7:0] bval(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    always @(negedge clk) begin
        cyc = cyc + 1;
        mem_gnt = 1'b0;
        mem_rvalid = 1'b0;
        if (rst) begin
            busy = 1'b0;
            hold = 0;
        end else if (!busy) begin
            if (mem_req) begin
                if (hold == 0) first_addr = mem_addr;
                else if (mem_addr != first_addr) addr_moved++;
                if (hold >= gnt_delay) begin
                    mem_gnt = 1'b1;
                    busy = 1'b1;
                    wcnt = 0;
                    hold = 0;
                    req_addr = mem_addr;
                    if (ga_n < 64) begin
                        ga_addr[ga_n] = int'(mem_addr);
                        ga_cyc[ga_n] = cyc;
                    end
                    ga_n++;
                end else begin
                    hold++;
                end
            end
        end else begin
            wcnt++;
            if (wcnt == resp_delay && !req_addr[AW-1]) begin
                mem_rvalid = 1'b1;
                mem_rdata = bval(req_addr);
                busy = 1'b0;
            end else if (wcnt >= TMO + 1) begin
                busy = 1'b0;
            end
        end
        if (tx_load) begin
            if (ld_n < 64) begin
                ld_line[ld_n] = int'(tx_line);
                ld_data[ld_n] = int'(tx_data);
            end
            ld_n++;
        end
        if (done_irq) begin
            if (dn_n < 16) dn_line[dn_n] = int'(done_line);
            dn_n++;
        end
        if (nxm_irq) begin
            nx_n++;
            nx_cyc = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        ld_n = 0; ga_n = 0; dn_n = 0; nx_n = 0; addr_moved = 0;
    endtask

    task automatic load(input int line, input logic [AW-1:0] a, input int n);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_line = LW'(line);
        cfg_addr = a;
        cfg_count = CW'(n);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        idle(3);
        check(mem_req == 1'b0, "R1 mem_req", int'(mem_req), 0);
        check(line_active == '0, "R1 line_active", int'(line_active), 0);
        check(!done_irq && !nxm_irq && !tx_load, "R1 pulses", int'({done_irq, nxm_irq, tx_load}), 0);
        check(nxm_line == '0, "R1 nxm_line", int'(nxm_line), 0);
    endtask

    task automatic t_single();
        clear_logs();
        line_en = '1;
        thr_empty = '1;
        gnt_delay = 3;
        load(3, 18'h00100, 3);
        idle(80);
        check(ld_n == 3, "R7 byte count", ld_n, 3);
        for (int i = 0; i < 3; i++) begin
            check(ld_line[i] == 3, "R5 tx_line", ld_line[i], 3);
            check(ld_data[i] == int'(bval(AW'(32'h100 + i))), "R5 tx_data", ld_data[i], int'(bval(AW'(32'h100 + i))));
            check(ga_addr[i] == 32'h100 + i, "R6 address", ga_addr[i], 32'h100 + i);
        end
        check(ga_n == 3 && addr_moved == 0, "R4 one request per byte, stable", ga_n * 256 + addr_moved, 3 * 256);
        check(dn_n == 1 && dn_line[0] == 3, "R7 done_line", dn_n * 256 + dn_line[0], 256 + 3);
        check(line_active == '0, "R7 active cleared", int'(line_active), 0);
        gnt_delay = 0;
    endtask

    task automatic t_round_robin();
        int exp_line [6];
        exp_line = '{5, 9, 1, 5, 9, 1};
        clear_logs();
        line_en = '0;
        load(1, 18'h00200, 2);
        load(5, 18'h00300, 2);
        load(9, 18'h00400, 2);
        idle(5);
        check(ld_n == 0 && line_active == 16'h0222, "R3 disabled lines wait", int'(line_active), 16'h0222);
        line_en = '1;
        idle(80);
        check(ld_n == 6, "R8 total bytes", ld_n, 6);
        for (int i = 0; i < 6; i++) begin
            check(ld_line[i] == exp_line[i], "R8 service order", ld_line[i], exp_line[i]);
        end
        check(ld_data[3] == int'(bval(18'h00301)), "R6 second byte line 5", ld_data[3], int'(bval(18'h00301)));
        check(dn_n == 3 && dn_line[2] == 1, "R7 last completion", dn_n * 256 + dn_line[2], 3 * 256 + 1);
    endtask

    task automatic t_gating();
        clear_logs();
        thr_empty[6] = 1'b0;
        load(6, 18'h00500, 1);
        idle(30);
        check(ld_n == 0 && ga_n == 0, "R3 holding full blocks fetch", ld_n, 0);
        check(line_active[6] == 1'b1, "R3 active kept", int'(line_active[6]), 1);
        line_en[6] = 1'b0;
        thr_empty[6] = 1'b1;
        idle(30);
        check(ld_n == 0, "R3 disabled blocks fetch", ld_n, 0);
        line_en[6] = 1'b1;
        idle(30);
        check(ld_n == 1 && ld_line[0] == 6, "R3 released line served", ld_n * 256 + ld_line[0], 256 + 6);
    endtask

    task automatic t_zero_count();
        clear_logs();
        load(4, 18'h00600, 0);
        idle(20);
        check(line_active == '0, "R2 zero count not active", int'(line_active), 0);
        check(ld_n == 0 && ga_n == 0, "R2 zero count not fetched", ga_n, 0);
    endtask

    task automatic t_late_response();
        clear_logs();
        resp_delay = TMO;
        load(2, 18'h00700, 1);
        idle(40);
        check(nx_n == 0, "R9 last-cycle response not a fault", nx_n, 0);
        check(ld_n == 1 && ld_data[0] == int'(bval(18'h00700)), "R9 last-cycle data delivered", ld_data[0], int'(bval(18'h00700)));
        resp_delay = 2;
    endtask

    task automatic t_fault();
        clear_logs();
        line_en = '0;
        load(7, 18'h20010, 4);
        load(8, 18'h00800, 1);
        line_en = '1;
        idle(80);
        check(nx_n == 1, "R9 one fault pulse", nx_n, 1);
        check(nxm_line == 7, "R9 nxm_line latched", int'(nxm_line), 7);
        check(nx_cyc - ga_cyc[0] == TMO + 1, "R9 fault timing", nx_cyc - ga_cyc[0], TMO + 1);
        check(line_active == '0, "R9 faulting line dropped", int'(line_active), 0);
        check(ld_n == 1 && ld_line[0] == 8, "R9 scan continues", ld_n * 256 + ld_line[0], 256 + 8);
        check(dn_n == 1 && dn_line[0] == 8, "R7 done after fault", dn_n * 256 + dn_line[0], 256 + 8);
    endtask

    initial begin
        rst = 1'b1;
        idle(4);
        t_reset();
        rst = 1'b0;
        idle(2);
        t_reset();
        t_single();
        t_round_robin();
        t_gating();
        t_zero_count();
        t_late_response();
        t_fault();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule